// File: doc/BRIEF.md
# Cell Reassembly Receive Buffer Filler

This block takes fixed 48-byte cell payloads. Each cell is tagged with a channel number, an end-of-frame flag and, on the closing cell, the frame length. The block places each payload into the receive buffers of that channel. Every channel owns a ring of descriptors in a small external descriptor store. Each descriptor gives a buffer start address, an empty flag that says the buffer may be filled, and a wrap flag that marks the last descriptor of the ring. A context for each channel holds the ring base, the current descriptor index, the next write address, the bytes already placed in the open buffer, and the bytes of the current frame written so far.

The control path is one state machine with five states. ST_IDLE accepts a cell or a ring-base configuration. ST_FETCH issues a descriptor read when the channel has no open buffer. ST_CHECK judges the returned descriptor. ST_WRITE emits one memory write for the cell and, when the buffer closes, a status pulse. ST_DROP emits a busy or configuration-error pulse and discards the cell.

The transitions are as follows. ST_IDLE goes to ST_DROP on a bad configured length, to ST_WRITE when the buffer is already open, and to ST_FETCH otherwise. ST_FETCH always goes to ST_CHECK. ST_CHECK goes to ST_WRITE for a usable descriptor and to ST_DROP otherwise. ST_WRITE and ST_DROP both return to ST_IDLE.

A buffer that is not the last of its frame closes only when it holds exactly the configured length. The last buffer of a frame is cut short, so that AAL5 padding in the final cell never reaches memory.

Top module: `cell_rx_filler`

## Requirements
- R1: After reset, `cell_ready` is high and `desc_rd_en`, `wr_valid`, `sts_valid`, `busy` and `cfg_err` are low.
- R2: A pulse on `cfg_we` sets the ring base of channel `cfg_ch` to `cfg_base`, moves its current descriptor index to that base, closes any open buffer and clears the channel's frame byte count. The next cell on that channel therefore reads descriptor `cfg_base`.
- R3: A cell on a channel with no open buffer causes a descriptor read at the channel's current index one cycle after acceptance. Its write reaches `wr_addr` = descriptor address three cycles after acceptance. A cell on a channel with an open buffer is written one cycle after acceptance, at the previous write address plus the previous write length. `wr_data` carries the payload.
- R4: A buffer that does not end a frame closes when its byte count reaches `buf_len`. The status pulse then carries `sts_len` = `buf_len`, `sts_last` = 0, the channel and the descriptor index. The frame continues in the next descriptor.
- R5: On an end-of-frame cell, the useful length is `frame_len` minus the frame bytes already written, limited to 0..48. Only that many bytes are written. No write is issued when the useful length is 0.
- R6: An end-of-frame cell always closes its buffer with `sts_last` = 1 and `sts_len` = the bytes placed in that buffer. When the same cell also fills the buffer to `buf_len`, exactly one status pulse is emitted.
- R7: When a buffer closes, the next descriptor index is the ring base if the closed descriptor had its wrap flag set. Otherwise it is the index plus one, modulo the store size.
- R8: If the fetched descriptor is empty but its buffer address has any of bits [3:0] set, `cfg_err` pulses three cycles after acceptance. The cell is dropped and the context is unchanged.
- R9: If `buf_len` is zero or not a multiple of 48 when a cell is accepted, `cfg_err` pulses one cycle later. No descriptor is read, the cell is dropped and the context is unchanged.
- R10: If the fetched descriptor has `desc_empty` = 0, `busy` pulses three cycles after acceptance. The cell is dropped and the context is unchanged.
- R11: Only one cell is in flight. `cell_ready` falls after an acceptance and rises again only when the machine is back in ST_IDLE. It is also low while `cfg_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cell_valid | input | 1 | Cell offered |
| cell_ready | output | 1 | Cell accepted on this edge when valid |
| cell_ch | input | 2 | Channel of the cell |
| cell_eof | input | 1 | Cell ends its frame |
| cell_frame_len | input | 16 | Frame byte length, used on end-of-frame cells |
| cell_data | input | 384 | 48-byte payload |
| buf_len | input | 16 | Configured receive buffer length in bytes |
| cfg_we | input | 1 | Ring-base configuration strobe |
| cfg_ch | input | 2 | Channel being configured |
| cfg_base | input | 4 | Ring base descriptor index |
| desc_rd_en | output | 1 | Descriptor read request |
| desc_rd_ptr | output | 4 | Descriptor index to read |
| desc_buf_addr | input | 32 | Buffer address of the descriptor, one cycle after the read |
| desc_empty | input | 1 | Descriptor available for filling |
| desc_wrap | input | 1 | Descriptor is the last of its ring |
| wr_valid | output | 1 | Memory write strobe |
| wr_addr | output | 32 | Write byte address |
| wr_len | output | 6 | Bytes to write, 1..48 |
| wr_data | output | 384 | Payload to write |
| sts_valid | output | 1 | Buffer closed |
| sts_ch | output | 2 | Channel of the closed buffer |
| sts_desc | output | 4 | Descriptor index of the closed buffer |
| sts_len | output | 16 | Bytes placed in the closed buffer |
| sts_last | output | 1 | Closed buffer ends a frame |
| busy | output | 1 | Cell dropped: descriptor not empty |
| cfg_err | output | 1 | Cell dropped: bad alignment or length |

## Verification
The case that matters here is an end-of-frame cell that also brings its buffer to exactly `buf_len`. That one cycle is where the full-buffer close and the frame-end close coincide, and together with the ring wrap it becomes a single status event. The bench provokes it with a two-cell frame on a 96-byte buffer whose descriptor carries the wrap flag. It accepts the result only if exactly one status pulse appears, with last set and length 96, and the channel's next fetch returns to its ring base. A second overlap, the zero-length trim, also closes a buffer with no write at all. The bench judges it by cycle-exact comparison against its own model.

// File: rtl/cell_rx_pkg.sv
package cell_rx_pkg;

    localparam int CELL_BYTES_DEF = 48;
    localparam int ALIGN_BITS_DEF = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_WRITE,
        ST_DROP
    } fill_state_e;

endpackage

// File: rtl/rbf_ctx_bank.sv
module rbf_ctx_bank #(
    parameter int NCH    = 4,
    parameter int CH_W   = 2,
    parameter int DESC_W = 4,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CH_W-1:0]   rd_ch,
    output logic [DESC_W-1:0] rd_base,
    output logic [DESC_W-1:0] rd_ptr,
    output logic              rd_wrap,
    output logic              rd_open,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [LEN_W-1:0]  rd_cnt,
    output logic [LEN_W-1:0]  rd_fbytes,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [DESC_W-1:0] wr_base,
    input  logic [DESC_W-1:0] wr_ptr,
    input  logic              wr_wrap,
    input  logic              wr_open,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LEN_W-1:0]  wr_cnt,
    input  logic [LEN_W-1:0]  wr_fbytes
);

    logic [DESC_W-1:0] base_a   [NCH];
    logic [DESC_W-1:0] ptr_a    [NCH];
    logic              wrap_a   [NCH];
    logic              open_a   [NCH];
    logic [ADDR_W-1:0] addr_a   [NCH];
    logic [LEN_W-1:0]  cnt_a    [NCH];
    logic [LEN_W-1:0]  fbytes_a [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic [DESC_W-1:0] base_q;
        logic [DESC_W-1:0] ptr_q;
        logic              wrap_q;
        logic              open_q;
        logic [ADDR_W-1:0] addr_q;
        logic [LEN_W-1:0]  cnt_q;
        logic [LEN_W-1:0]  fbytes_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q   <= '0;
                ptr_q    <= '0;
                wrap_q   <= 1'b0;
                open_q   <= 1'b0;
                addr_q   <= '0;
                cnt_q    <= '0;
                fbytes_q <= '0;
            end else if (wr_en && wr_ch == CH_W'(g)) begin
                base_q   <= wr_base;
                ptr_q    <= wr_ptr;
                wrap_q   <= wr_wrap;
                open_q   <= wr_open;
                addr_q   <= wr_addr;
                cnt_q    <= wr_cnt;
                fbytes_q <= wr_fbytes;
            end
        end

        assign base_a[g]   = base_q;
        assign ptr_a[g]    = ptr_q;
        assign wrap_a[g]   = wrap_q;
        assign open_a[g]   = open_q;
        assign addr_a[g]   = addr_q;
        assign cnt_a[g]    = cnt_q;
        assign fbytes_a[g] = fbytes_q;
    end

    assign rd_base   = base_a[rd_ch];
    assign rd_ptr    = ptr_a[rd_ch];
    assign rd_wrap   = wrap_a[rd_ch];
    assign rd_open   = open_a[rd_ch];
    assign rd_addr   = addr_a[rd_ch];
    assign rd_cnt    = cnt_a[rd_ch];
    assign rd_fbytes = fbytes_a[rd_ch];

endmodule

// File: rtl/rbf_len_calc.sv
module rbf_len_calc #(
    parameter int LEN_W      = 16,
    parameter int CNT_W      = 6,
    parameter int CELL_BYTES = 48,
    parameter int ALIGN_BITS = 4
) (
    input  logic [LEN_W-1:0]      frame_len,
    input  logic [LEN_W-1:0]      fill_bytes,
    input  logic [LEN_W-1:0]      buf_len,
    input  logic [ALIGN_BITS-1:0] addr_lo,
    output logic [CNT_W-1:0]      tail_len,
    output logic                  len_bad,
    output logic                  addr_bad
);

    localparam logic [LEN_W-1:0] CELL_L = LEN_W'(CELL_BYTES);

    logic [LEN_W-1:0] remain;

    assign remain = frame_len - fill_bytes;

    always_comb begin
        if (frame_len <= fill_bytes) begin
            tail_len = '0;
        end else if (remain > CELL_L) begin
            tail_len = CNT_W'(CELL_BYTES);
        end else begin
            tail_len = remain[CNT_W-1:0];
        end
    end

    assign len_bad  = (buf_len == '0) || ((buf_len % CELL_L) != '0);
    assign addr_bad = |addr_lo;

endmodule

// File: rtl/cell_rx_filler.sv
module cell_rx_filler
    import cell_rx_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int DESC_W     = 4,
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int CELL_BYTES = CELL_BYTES_DEF,
    parameter int ALIGN_BITS = ALIGN_BITS_DEF,
    localparam int CH_W      = $clog2(NCH),
    localparam int CNT_W     = $clog2(CELL_BYTES + 1),
    localparam int DATA_W    = CELL_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cell_valid,
    output logic              cell_ready,
    input  logic [CH_W-1:0]   cell_ch,
    input  logic              cell_eof,
    input  logic [LEN_W-1:0]  cell_frame_len,
    input  logic [DATA_W-1:0] cell_data,
    input  logic [LEN_W-1:0]  buf_len,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [DESC_W-1:0] cfg_base,
    output logic              desc_rd_en,
    output logic [DESC_W-1:0] desc_rd_ptr,
    input  logic [ADDR_W-1:0] desc_buf_addr,
    input  logic              desc_empty,
    input  logic              desc_wrap,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [CNT_W-1:0]  wr_len,
    output logic [DATA_W-1:0] wr_data,
    output logic              sts_valid,
    output logic [CH_W-1:0]   sts_ch,
    output logic [DESC_W-1:0] sts_desc,
    output logic [LEN_W-1:0]  sts_len,
    output logic              sts_last,
    output logic              busy,
    output logic              cfg_err
);

    fill_state_e state, state_nx;

    // captured cell
    logic [CH_W-1:0]   cur_ch;
    logic              cur_eof;
    logic [LEN_W-1:0]  cur_flen;
    logic [DATA_W-1:0] cur_data;
    // captured write / status
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  cur_len;
    logic              close_q;
    logic [LEN_W-1:0]  sts_len_q;
    logic [DESC_W-1:0] sts_desc_q;
    logic              busy_q;
    logic              cfgerr_q;

    // context bank
    logic [CH_W-1:0]   rd_ch;
    logic [DESC_W-1:0] rd_base, rd_ptr;
    logic              rd_wrap, rd_open;
    logic [ADDR_W-1:0] rd_addr;
    logic [LEN_W-1:0]  rd_cnt, rd_fbytes;
    logic              ctx_we;
    logic [CH_W-1:0]   ctx_ch;
    logic [DESC_W-1:0] ctx_base, ctx_ptr;
    logic              ctx_wrap, ctx_open;
    logic [ADDR_W-1:0] ctx_addr;
    logic [LEN_W-1:0]  ctx_cnt, ctx_fbytes;

    // length unit
    logic [CNT_W-1:0]  tail_len;
    logic              len_bad, addr_bad;

    // fill datapath
    logic              accept;
    logic              in_idle;
    logic              eof_sel;
    logic [CNT_W-1:0]  fill_len;
    logic [ADDR_W-1:0] start_addr;
    logic [LEN_W-1:0]  start_cnt;
    logic              wrap_sel;
    logic [LEN_W-1:0]  new_cnt;
    logic              close_now;
    logic              go_write;
    logic              cfg_take;

    assign in_idle  = (state == ST_IDLE);
    assign accept   = cell_valid && cell_ready;
    assign cfg_take = in_idle && cfg_we;
    assign rd_ch    = in_idle ? cell_ch : cur_ch;

    rbf_ctx_bank #(
        .NCH(NCH), .CH_W(CH_W), .DESC_W(DESC_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
    ) ctx_i (
        .clk(clk), .rst_n(rst_n),
        .rd_ch(rd_ch), .rd_base(rd_base), .rd_ptr(rd_ptr), .rd_wrap(rd_wrap),
        .rd_open(rd_open), .rd_addr(rd_addr), .rd_cnt(rd_cnt), .rd_fbytes(rd_fbytes),
        .wr_en(ctx_we), .wr_ch(ctx_ch), .wr_base(ctx_base), .wr_ptr(ctx_ptr),
        .wr_wrap(ctx_wrap), .wr_open(ctx_open), .wr_addr(ctx_addr), .wr_cnt(ctx_cnt),
        .wr_fbytes(ctx_fbytes)
    );

    rbf_len_calc #(
        .LEN_W(LEN_W), .CNT_W(CNT_W), .CELL_BYTES(CELL_BYTES), .ALIGN_BITS(ALIGN_BITS)
    ) len_i (
        .frame_len(in_idle ? cell_frame_len : cur_flen),
        .fill_bytes(rd_fbytes),
        .buf_len(buf_len),
        .addr_lo(desc_buf_addr[ALIGN_BITS-1:0]),
        .tail_len(tail_len),
        .len_bad(len_bad),
        .addr_bad(addr_bad)
    );

    // where the cell lands and whether the buffer closes
    assign eof_sel    = in_idle ? cell_eof : cur_eof;
    assign fill_len   = eof_sel ? tail_len : CNT_W'(CELL_BYTES);
    assign start_addr = in_idle ? rd_addr : desc_buf_addr;
    assign start_cnt  = in_idle ? rd_cnt : '0;
    assign wrap_sel   = in_idle ? rd_wrap : desc_wrap;
    assign new_cnt    = start_cnt + LEN_W'(fill_len);
    assign close_now  = eof_sel || (new_cnt >= buf_len);
    assign go_write   = (in_idle && accept && !len_bad && rd_open)
                      || (state == ST_CHECK && desc_empty && !addr_bad);

    // context write-back: configuration or fill update
    always_comb begin
        ctx_we = cfg_take || go_write;
        if (cfg_take) begin
            ctx_ch     = cfg_ch;
            ctx_base   = cfg_base;
            ctx_ptr    = cfg_base;
            ctx_wrap   = 1'b0;
            ctx_open   = 1'b0;
            ctx_addr   = '0;
            ctx_cnt    = '0;
            ctx_fbytes = '0;
        end else begin
            ctx_ch     = rd_ch;
            ctx_base   = rd_base;
            ctx_ptr    = close_now ? (wrap_sel ? rd_base : rd_ptr + 1'b1) : rd_ptr;
            ctx_wrap   = wrap_sel;
            ctx_open   = !close_now;
            ctx_addr   = start_addr + ADDR_W'(fill_len);
            ctx_cnt    = close_now ? '0 : new_cnt;
            ctx_fbytes = eof_sel ? '0 : rd_fbytes + LEN_W'(fill_len);
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    if (len_bad)      state_nx = ST_DROP;
                    else if (rd_open) state_nx = ST_WRITE;
                    else              state_nx = ST_FETCH;
                end
            end
            ST_FETCH: state_nx = ST_CHECK;
            ST_CHECK: state_nx = go_write ? ST_WRITE : ST_DROP;
            ST_WRITE: state_nx = ST_IDLE;
            ST_DROP:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // captured cell, write and status fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_ch     <= '0;
            cur_eof    <= 1'b0;
            cur_flen   <= '0;
            cur_data   <= '0;
            cur_addr   <= '0;
            cur_len    <= '0;
            close_q    <= 1'b0;
            sts_len_q  <= '0;
            sts_desc_q <= '0;
            busy_q     <= 1'b0;
            cfgerr_q   <= 1'b0;
        end else begin
            if (in_idle && accept) begin
                cur_ch   <= cell_ch;
                cur_eof  <= cell_eof;
                cur_flen <= cell_frame_len;
                cur_data <= cell_data;
                busy_q   <= 1'b0;
                cfgerr_q <= len_bad;
            end
            if (state == ST_CHECK) begin
                busy_q   <= !desc_empty;
                cfgerr_q <= desc_empty && addr_bad;
            end
            if (go_write) begin
                cur_addr   <= start_addr;
                cur_len    <= fill_len;
                close_q    <= close_now;
                sts_len_q  <= new_cnt;
                sts_desc_q <= rd_ptr;
            end
        end
    end

    // outputs
    always_comb begin
        cell_ready = 1'b0;
        desc_rd_en = 1'b0;
        wr_valid   = 1'b0;
        sts_valid  = 1'b0;
        busy       = 1'b0;
        cfg_err    = 1'b0;
        unique case (state)
            ST_IDLE:  cell_ready = !cfg_we;
            ST_FETCH: desc_rd_en = 1'b1;
            ST_CHECK: ;
            ST_WRITE: begin
                wr_valid  = (cur_len != '0);
                sts_valid = close_q;
            end
            ST_DROP: begin
                busy    = busy_q;
                cfg_err = cfgerr_q;
            end
            default: ;
        endcase
    end

    assign desc_rd_ptr = rd_ptr;
    assign wr_addr     = cur_addr;
    assign wr_len      = cur_len;
    assign wr_data     = cur_data;
    assign sts_ch      = cur_ch;
    assign sts_desc    = sts_desc_q;
    assign sts_len     = sts_len_q;
    assign sts_last    = cur_eof;

    // R10
    full_desc_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK && !desc_empty) |=> (busy && !wr_valid && !sts_valid));

    // R8
    misalign_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK && desc_empty && (|desc_buf_addr[ALIGN_BITS-1:0]))
            |=> (cfg_err && !wr_valid));

    // R4
    exact_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_valid && !sts_last) |-> (sts_len == buf_len));

    // R11
    single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_valid && cell_ready) |=> !cell_ready);

    // R5
    tail_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_len != '0 && wr_len <= CNT_W'(CELL_BYTES)));

    // R6
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sts_valid, busy, cfg_err}));

endmodule

// File: tb/cell_rx_filler_tb_top.sv
module cell_rx_filler_tb_top;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         cell_valid;
    logic         cell_ready;
    logic [1:0]   cell_ch;
    logic         cell_eof;
    logic [15:0]  cell_frame_len;
    logic [383:0] cell_data;
    logic [15:0]  buf_len;
    logic         cfg_we;
    logic [1:0]   cfg_ch;
    logic [3:0]   cfg_base;
    logic         desc_rd_en;
    logic [3:0]   desc_rd_ptr;
    logic [31:0]  desc_buf_addr;
    logic         desc_empty;
    logic         desc_wrap;
    logic         wr_valid;
    logic [31:0]  wr_addr;
    logic [5:0]   wr_len;
    logic [383:0] wr_data;
    logic         sts_valid;
    logic [1:0]   sts_ch;
    logic [3:0]   sts_desc;
    logic [15:0]  sts_len;
    logic         sts_last;
    logic         busy;
    logic         cfg_err;

    always #5 clk = ~clk;

    cell_rx_filler dut_i (
        .clk(clk), .rst_n(rst_n),
        .cell_valid(cell_valid), .cell_ready(cell_ready), .cell_ch(cell_ch),
        .cell_eof(cell_eof), .cell_frame_len(cell_frame_len), .cell_data(cell_data),
        .buf_len(buf_len), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_base(cfg_base),
        .desc_rd_en(desc_rd_en), .desc_rd_ptr(desc_rd_ptr),
        .desc_buf_addr(desc_buf_addr), .desc_empty(desc_empty), .desc_wrap(desc_wrap),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_len(wr_len), .wr_data(wr_data),
        .sts_valid(sts_valid), .sts_ch(sts_ch), .sts_desc(sts_desc), .sts_len(sts_len),
        .sts_last(sts_last), .busy(busy), .cfg_err(cfg_err)
    );

    // descriptor store, one-cycle read
    logic [31:0] dm_addr  [16];
    bit          dm_empty [16];
    bit          dm_wrap  [16];

    always @(posedge clk) begin
        if (desc_rd_en) begin
            desc_buf_addr <= dm_addr[desc_rd_ptr];
            desc_empty    <= dm_empty[desc_rd_ptr];
            desc_wrap     <= dm_wrap[desc_rd_ptr];
        end
    end

    // reference context
    int m_base [4];
    int m_ptr  [4];
    int m_wrap [4];
    int m_open [4];
    int m_addr [4];
    int m_cnt  [4];
    int m_fb   [4];

    int n_chk  = 0;
    int n_fail = 0;
    int seq    = 0;

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic cfg(input int ch, input int base);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_ch   = 2'(ch);
        cfg_base = 4'(base);
        @(negedge clk);
        cfg_we = 1'b0;
        m_base[ch] = base;
        m_ptr[ch]  = base;
        m_wrap[ch] = 0;
        m_open[ch] = 0;
        m_cnt[ch]  = 0;
        m_fb[ch]   = 0;
    endtask

    // kind: 0 length error, 1 open write, 2 fetched write, 3 busy, 4 misaligned
    task automatic send(input int ch, input bit eof, input int flen, input string rtag);
        int kind, k, rp, tail, scnt, wlen, ncnt, wrapb;
        bit cls;
        logic [31:0]  waddr;
        logic [383:0] data;
        data = {12{32'hC0DE0000 + 32'(seq)}};
        seq++;
        rp = m_ptr[ch];
        if (flen <= m_fb[ch])           tail = 0;
        else if (flen - m_fb[ch] > 48)  tail = 48;
        else                            tail = flen - m_fb[ch];
        if (buf_len == 0 || (buf_len % 48) != 0) kind = 0;
        else if (m_open[ch] != 0)                kind = 1;
        else if (!dm_empty[rp])                  kind = 3;
        else if (dm_addr[rp][3:0] != 0)          kind = 4;
        else                                     kind = 2;
        k = (kind <= 1) ? 1 : 3;
        waddr = (kind == 1) ? 32'(m_addr[ch]) : dm_addr[rp];
        scnt  = (kind == 1) ? m_cnt[ch] : 0;
        wrapb = (kind == 1) ? m_wrap[ch] : int'(dm_wrap[rp]);
        wlen  = eof ? tail : 48;
        ncnt  = scnt + wlen;
        cls   = eof || (ncnt >= int'(buf_len));

        @(negedge clk);
        cell_valid     = 1'b1;
        cell_ch        = 2'(ch);
        cell_eof       = eof;
        cell_frame_len = 16'(flen);
        cell_data      = data;
        @(posedge clk);
        for (int c = 1; c <= 4; c++) begin
            @(negedge clk);
            if (c == 1) cell_valid = 1'b0;
            chk("R11", "cell_ready", cell_ready, (c > k) ? 1 : 0);
            chk("R3", "desc_rd_en", desc_rd_en, (c == 1 && kind >= 2) ? 1 : 0);
            if (c == 1 && kind >= 2) chk(rtag, "desc_rd_ptr", desc_rd_ptr, 64'(rp));
            chk(eof ? "R5" : "R3", "wr_valid", wr_valid,
                (c == k && (kind == 1 || kind == 2) && wlen != 0) ? 1 : 0);
            if (c == k && (kind == 1 || kind == 2) && wlen != 0) begin
                chk(eof ? "R5" : "R3", "wr_addr", wr_addr, 64'(waddr));
                chk(eof ? "R5" : "R3", "wr_len", wr_len, 64'(wlen));
                chk("R3", "wr_data", 64'(wr_data == data), 1);
            end
            chk(eof ? "R6" : "R4", "sts_valid", sts_valid,
                (c == k && (kind == 1 || kind == 2) && cls) ? 1 : 0);
            if (c == k && (kind == 1 || kind == 2) && cls) begin
                chk(eof ? "R6" : "R4", "sts_ch", sts_ch, 64'(ch));
                chk(eof ? "R6" : "R4", "sts_desc", sts_desc, 64'(rp));
                chk(eof ? "R6" : "R4", "sts_len", sts_len, 64'(ncnt));
                chk(eof ? "R6" : "R4", "sts_last", sts_last, 64'(eof));
            end
            chk("R10", "busy", busy, (c == k && kind == 3) ? 1 : 0);
            chk((kind == 0) ? "R9" : "R8", "cfg_err", cfg_err,
                (c == k && (kind == 0 || kind == 4)) ? 1 : 0);
        end

        if (kind == 1 || kind == 2) begin
            m_wrap[ch] = wrapb;
            if (cls) begin
                m_open[ch] = 0;
                m_cnt[ch]  = 0;
                m_ptr[ch]  = (wrapb != 0) ? m_base[ch] : ((m_ptr[ch] + 1) % 16);
            end else begin
                m_open[ch] = 1;
                m_cnt[ch]  = ncnt;
            end
            m_addr[ch] = int'(waddr) + wlen;
            m_fb[ch]   = eof ? 0 : m_fb[ch] + wlen;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cell_valid = 1'b0; cell_ch = '0; cell_eof = 1'b0; cell_frame_len = '0;
        cell_data = '0; buf_len = 16'd96; cfg_we = 1'b0; cfg_ch = '0; cfg_base = '0;
        desc_buf_addr = '0; desc_empty = 1'b0; desc_wrap = 1'b0;
        for (int i = 0; i < 16; i++) begin
            dm_addr[i]  = 32'h1000 + 32'(i) * 32'h100;
            dm_empty[i] = 1'b1;
            dm_wrap[i]  = (i == 1 || i == 5 || i == 9 || i == 13);
        end
        dm_addr[8]  = 32'h1804;
        dm_empty[12] = 1'b0;
        for (int i = 0; i < 4; i++) begin
            m_base[i] = 0; m_ptr[i] = 0; m_wrap[i] = 0; m_open[i] = 0;
            m_addr[i] = 0; m_cnt[i] = 0; m_fb[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "cell_ready", cell_ready, 1);
        chk("R1", "desc_rd_en", desc_rd_en, 0);
        chk("R1", "wr_valid", wr_valid, 0);
        chk("R1", "sts_valid", sts_valid, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "cfg_err", cfg_err, 0);

        cfg(0, 0);
        cfg(1, 4);
        cfg(2, 8);
        cfg(3, 12);

        send(0, 1'b0, 0, "R2");    // first buffer of ch0 at its base
        send(0, 1'b0, 0, "R4");    // fills 96: non-final close
        send(0, 1'b1, 100, "R3");  // tail of 4 bytes in desc1 (wrap)
        send(1, 1'b1, 30, "R3");   // single-cell frame
        send(1, 1'b0, 0, "R3");    // desc5 opened
        send(0, 1'b0, 0, "R7");    // ch0 back at base after wrap
        send(1, 1'b1, 96, "R6");   // full and end-of-frame together, wrap
        send(2, 1'b0, 0, "R8");    // misaligned buffer
        dm_addr[8] = 32'h1800;
        send(2, 1'b0, 0, "R8");    // same descriptor read again
        send(3, 1'b0, 0, "R10");   // descriptor not empty
        dm_empty[12] = 1'b1;
        send(3, 1'b0, 0, "R10");   // same descriptor retried
        send(0, 1'b1, 40, "R5");   // zero useful bytes: close without write
        send(1, 1'b0, 0, "R7");    // ch1 fetch returns to base 4
        buf_len = 16'd100;
        send(2, 1'b0, 0, "R9");    // bad configured length
        buf_len = 16'd96;
        send(2, 1'b1, 60, "R5");   // ch2 tail after a 48-byte start
        cfg(3, 12);
        send(3, 1'b0, 0, "R2");    // open buffer discarded by reconfiguration
        buf_len = 16'd48;
        send(1, 1'b1, 50, "R4");   // open at 48 on 48-byte buffers
        send(1, 1'b1, 10, "R6");

        repeat (2) @(negedge clk);
        summary();
        $finish;
    end

endmodule